// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Priority Arbiter

This block selects one winner among eight peripheral interrupt request lines every clock cycle. Each line owns a 4-bit priority field, and all eight fields sit in a single 32-bit configuration word. Software writes the word with a strobe and reads it back at any time. The arbiter compares the pending lines and reports three things: whether any line is pending, the index of the winner, and whether the winner must raise the high-level (critical) interrupt or the ordinary low-level one.

Line 0 is special. When it is pending it always wins and always signals on the high output. Its field in the configuration word can still be written and read back, but the arbiter ignores it. For lines 1 to 7, the full 4-bit field is compared as an unsigned number, so a field with its top bit set outranks every field with that bit clear. The same top bit selects which of the two interrupt outputs the winner drives. When two pending lines have equal fields, the lower index wins.

The winner is chosen combinationally from the current request vector and registered once. The outputs therefore follow the requests with one cycle of latency.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `cfg_rdata` is zero and `irq_valid`, `irq_idx`, `irq_hi` and `irq_lo` are all zero.
- R2: A word driven on `cfg_wdata` with `cfg_wr_en` high at a clock edge appears in full on `cfg_rdata` after that edge, including the line 0 field. Line i occupies bits [31-4i : 28-4i], so line 0 is the top nibble and line 7 is the bottom nibble.
- R3: Among pending lines 1 to 7, with line 0 idle, the line whose 4-bit field is largest as an unsigned number wins.
- R4: When several pending lines share the largest field value, zero included, the lowest index among them wins.
- R5: When line 0 is pending, the outputs show index 0 with `irq_hi` high and `irq_lo` low, whatever value the line 0 field and the other fields hold.
- R6: For a winner other than line 0, `irq_hi` equals bit 3 of its field and `irq_lo` is the inverse of that bit. Whenever `irq_valid` is high, exactly one of the two flags is high.
- R7: When no request is pending, the next outputs are `irq_valid`=0, `irq_idx`=0, `irq_hi`=0 and `irq_lo`=0.
- R8: The outputs after a clock edge reflect the request vector sampled at that edge. There is one cycle of latency.
- R9: A configuration write takes effect on arbitration from the cycle after the strobe. Requests sampled at the same edge as the write are ranked with the old configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 8 | Interrupt request lines, bit i is line i |
| cfg_wr_en | input | 1 | Write strobe for the priority word |
| cfg_wdata | input | 32 | Priority word to write |
| cfg_rdata | output | 32 | Current priority word |
| irq_valid | output | 1 | At least one line was pending |
| irq_idx | output | 3 | Index of the winning line |
| irq_hi | output | 1 | Winner raises the high-level interrupt |
| irq_lo | output | 1 | Winner raises the low-level interrupt |

## Verification
A wrong value held in the priority word shows directly on `cfg_rdata` one cycle after the write. It also shows on `irq_idx` or on the hi/lo flags the first cycle that two lines are pending together whose ranking depends on the corrupted field. A fault in the ranking scan or in the output register shows at the ports one cycle after the request pattern that exposes it. Tie patterns, line 0 with hostile field values, and requests presented in the same cycle as a write are driven on purpose, so that ordering and timing faults cannot hide behind random traffic.

// File: rtl/irq_arb_pkg.sv
// Package: shared defaults and the flag bundle used by the interrupt
// priority arbiter. Assumes all users size their ports from these defaults.
package irq_arb_pkg;
    localparam int unsigned DEF_NUM_SRC = 8;
    localparam int unsigned DEF_PRI_W   = 4;

    // Registered interrupt flags leaving the arbiter
    typedef struct packed {
        logic valid;
        logic hi;
        logic lo;
    } irq_flags_t;
endpackage

// File: rtl/irq_cfg_reg.sv
// Module: holds the packed priority word. Writes land on the clock edge
// that samples the strobe. Assumes a synchronous active-low reset.
module irq_cfg_reg #(
    parameter int unsigned CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);
    // Capture software writes, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= wdata;
    end
endmodule

// File: rtl/irq_rank_select.sv
// Module: combinational ranking of pending lines. Line 0 receives a key
// above every field value. Lines 1.. are ranked by their unsigned field.
// The scan runs upward and replaces the best only on a strictly larger
// key, so ties resolve to the lower index. Assumes cfg_low carries the
// fields of lines 1..NUM_SRC-1, with line 1 in the top nibble.
module irq_rank_select #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned PRI_W   = 4,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]           req,
    input  logic [(NUM_SRC-1)*PRI_W-1:0] cfg_low,
    output logic                         win_valid,
    output logic [IDX_W-1:0]             win_idx,
    output logic                         win_hi
);
    localparam int unsigned KEY_W = PRI_W + 1;

    logic [KEY_W-1:0] key  [NUM_SRC];
    logic             bank [NUM_SRC];

    // Line 0: fixed top key, always in the high bank
    assign key[0]  = {1'b1, {PRI_W{1'b0}}};
    assign bank[0] = 1'b1;

    // Lines 1..: key from the configured field, bank from its top bit
    for (genvar g = 1; g < NUM_SRC; g++) begin : g_key
        logic [PRI_W-1:0] field;
        assign field   = cfg_low[(NUM_SRC-1-g)*PRI_W +: PRI_W];
        assign key[g]  = {1'b0, field};
        assign bank[g] = field[PRI_W-1];
    end

    logic [KEY_W-1:0] best_key;

    // Upward scan keeping the first strictly largest pending key
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_hi    = 1'b0;
        best_key  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (!win_valid || key[i] > best_key)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_hi    = bank[i];
                best_key  = key[i];
            end
        end
    end
endmodule

// File: rtl/irq_out_stage.sv
// Module: output register of the arbiter. Splits the bank bit into the
// high and low interrupt flags and clears everything when nothing is
// pending. Assumes a synchronous active-low reset.
module irq_out_stage #(
    parameter int unsigned IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_valid,
    input  logic [IDX_W-1:0]        win_idx,
    input  logic                    win_hi,
    output irq_arb_pkg::irq_flags_t flags_q,
    output logic [IDX_W-1:0]        idx_q
);
    irq_arb_pkg::irq_flags_t flags_d;

    // Map the winner's bank onto exactly one interrupt flag
    always_comb begin
        flags_d.valid = win_valid;
        flags_d.hi    = win_valid & win_hi;
        flags_d.lo    = win_valid & ~win_hi;
    end

    // Register the decision: one cycle from request to outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            idx_q   <= '0;
        end else begin
            flags_q <= flags_d;
            idx_q   <= win_valid ? win_idx : '0;
        end
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
// Module: top of the peripheral interrupt priority arbiter. Holds the
// priority word, ranks the pending lines and registers the winner.
// Assumes line 0 is the fixed top-priority line, whose field is stored
// but never consulted.
module irq_prio_arbiter #(
    parameter int unsigned NUM_SRC = irq_arb_pkg::DEF_NUM_SRC,
    parameter int unsigned PRI_W   = irq_arb_pkg::DEF_PRI_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         req,
    input  logic                       cfg_wr_en,
    input  logic [NUM_SRC*PRI_W-1:0]   cfg_wdata,
    output logic [NUM_SRC*PRI_W-1:0]   cfg_rdata,
    output logic                       irq_valid,
    output logic [$clog2(NUM_SRC)-1:0] irq_idx,
    output logic                       irq_hi,
    output logic                       irq_lo
);
    localparam int unsigned CFG_W = NUM_SRC * PRI_W;
    localparam int unsigned LOW_W = (NUM_SRC - 1) * PRI_W;
    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    logic [CFG_W-1:0]        cfg_q;
    logic                    win_valid;
    logic [IDX_W-1:0]        win_idx;
    logic                    win_hi;
    irq_arb_pkg::irq_flags_t flags_q;

    irq_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    irq_rank_select #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_rank (
        .req       (req),
        .cfg_low   (cfg_q[LOW_W-1:0]),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_hi    (win_hi)
    );

    irq_out_stage #(.IDX_W(IDX_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_hi    (win_hi),
        .flags_q   (flags_q),
        .idx_q     (irq_idx)
    );

    // Drive ports from the stored word and the registered flags
    assign cfg_rdata = cfg_q;
    assign irq_valid = flags_q.valid;
    assign irq_hi    = flags_q.hi;
    assign irq_lo    = flags_q.lo;
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
// Module: property checker for the arbiter, attached through bind.
// Watches only the top-level ports.
module irq_prio_arbiter_chk #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned PRI_W   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SRC-1:0]         req,
    input logic                       cfg_wr_en,
    input logic [NUM_SRC*PRI_W-1:0]   cfg_wdata,
    input logic [NUM_SRC*PRI_W-1:0]   cfg_rdata,
    input logic                       irq_valid,
    input logic [$clog2(NUM_SRC)-1:0] irq_idx,
    input logic                       irq_hi,
    input logic                       irq_lo
);
    logic [NUM_SRC-1:0] req_d;
    logic               live_d;

    // Remember last cycle's requests and whether that cycle was out of reset
    always_ff @(posedge clk) begin
        req_d  <= req;
        live_d <= rst_n;
    end

    // R2: a written word is read back in full
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live_d && $past(cfg_wr_en) |-> cfg_rdata == $past(cfg_wdata));

    // R3: the winner was actually pending
    assert_winner_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live_d && irq_valid |-> req_d[irq_idx]);

    // R5: a pending line 0 always wins on the high output
    assert_line0_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_d && req_d[0] |-> irq_idx == '0 && irq_hi && !irq_lo);

    // R6: exactly one interrupt flag while valid
    assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $onehot({irq_hi, irq_lo}));

    // R7: no flags without a valid winner
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> !irq_hi && !irq_lo && irq_idx == '0);

    // R8: valid follows whether any line was pending one cycle earlier
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        live_d |-> irq_valid == (req_d != '0));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_valid (irq_valid),
    .irq_idx   (irq_idx),
    .irq_hi    (irq_hi),
    .irq_lo    (irq_lo)
);

// File: tb/irq_prio_arbiter_test.sv
`timescale 1ns/1ps
module irq_prio_arbiter_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  req;
    logic        cfg_wr_en;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        irq_valid;
    logic [2:0]  irq_idx;
    logic        irq_hi;
    logic        irq_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [5:0]  exp_out;
    logic [31:0] model_cfg;
    string       exp_tag;

    always #10 clk = ~clk;

    irq_prio_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req(req),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    // Expected {valid, idx[2:0], hi, lo} from the requirements
    function automatic logic [5:0] model(input logic [7:0] r, input logic [31:0] c);
        int best = -1;
        int best_p = -1;
        logic hi;
        for (int i = 0; i < N; i++) begin
            int p;
            p = (i == 0) ? 16 : int'(c[31-4*i -: 4]);
            if (r[i] && p > best_p) begin
                best = i;
                best_p = p;
            end
        end
        if (best < 0) return 6'b0;
        hi = (best == 0) ? 1'b1 : c[31-4*best];
        return {1'b1, 3'(best), hi, ~hi};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Check the outputs of the previous step, then drive the next one
    task automatic step(input logic [7:0] r, input logic wr, input logic [31:0] wd, input string tag);
        @(negedge clk);
        check(exp_tag, {26'b0, irq_valid, irq_idx, irq_hi, irq_lo}, {26'b0, exp_out});
        check("R2 readback", cfg_rdata, model_cfg);
        req = r;
        cfg_wr_en = wr;
        cfg_wdata = wd;
        exp_out = model(r, model_cfg);
        exp_tag = tag;
        if (wr) model_cfg = wd;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req = 8'hFF; cfg_wr_en = 1'b0; cfg_wdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1 reset rdata", cfg_rdata, 32'h0);
        check("R1 reset outputs", {28'b0, irq_valid, irq_hi, irq_lo, 1'b0}, 32'h0);
        check("R1 reset idx", {29'b0, irq_idx}, 32'h0);
        req = 8'h00; cfg_wdata = 32'h0;
        rst_n = 1'b1;
        model_cfg = 32'h0;
        exp_out = 6'b0;
        exp_tag = "R7 idle after reset";

        // R4: all fields zero, tie between lines 1 and 2
        step(8'b0000_0110, 1'b0, 32'h0, "R4 tie at zero");
        // R9: write lifts line 5 to 0x9 while lines 2 and 5 request
        step(8'b0010_0100, 1'b1, 32'h0000_0900, "R9 old config same cycle");
        step(8'b0010_0100, 1'b0, 32'h0, "R9 new config next cycle R6 hi");
        // R5: line 0 field zero, all others maximum
        step(8'b0000_0000, 1'b1, 32'h0FFF_FFFF, "R7 no request");
        step(8'hFF, 1'b0, 32'h0, "R5 line0 beats max fields");
        step(8'b0000_0001, 1'b1, 32'hF000_0000, "R5 line0 field ignored");
        // R6: low bank winner
        step(8'b1000_0010, 1'b1, 32'h0300_0007, "R7 idle after write");
        step(8'b1000_0010, 1'b0, 32'h0, "R3 larger field R6 lo");
        // R4: equal nonzero ties at the top bank
        step(8'b1111_1110, 1'b1, 32'h0A5A_A5AA, "R2 write");
        step(8'b1111_1110, 1'b0, 32'h0, "R4 tie nonzero");
        step(8'b1000_0000, 1'b0, 32'h0, "R3 single line 7");
        step(8'h00, 1'b0, 32'h0, "R8 drop requests");

        // Random traffic with occasional writes
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] r;
            r = 8'($urandom);
            if ($urandom_range(0, 3) == 0) r[0] = 1'b0;
            if ($urandom_range(0, 1) == 0) r = r & 8'($urandom);
            step(r, ($urandom_range(0, 7) == 0), $urandom, "R3 R4 R6 R8 random");
        end
        step(8'h00, 1'b0, 32'h0, "R8 final");
        @(negedge clk);
        check(exp_tag, {26'b0, irq_valid, irq_idx, irq_hi, irq_lo}, {26'b0, exp_out});
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule